// File: doc/BRIEF.md
# Keyed-Access Watchdog Timer

This block is a watchdog counter behind a small register bus. Software can change its settings only after it writes an unlock key to the counter offset. The block then opens a limited unlock window, and writes to the control and timeout registers are accepted only while that window is open. The count returns to zero only when a separate refresh key is written. If the count is allowed to reach the programmed timeout, the block emits a one-clock reset pulse and raises a sticky flag.

Both keys are 32 bits wide and are made of a low half and a high half. A mode bit in the control register selects how a key is delivered:

- With the mode bit set, the key arrives as one 32-bit word.
- With the mode bit clear, the key arrives as two 16-bit writes, low half first.

A recognised first half followed by a wrong second half is treated as an attack, and the reset fires at once. An optional prescaler slows the count by a factor of 256.

The bus is a plain register port: a one-cycle write strobe and a combinational read of the addressed register. It has no handshake and no back-pressure, and every access completes in the cycle it is presented. Clock-source selection and the two low-power run bits are stored and can be read back, but they have no effect inside this block.

Top module: `keyed_wdog`

## Requirements
- R1: After reset, `wdog_rst` is 0. The control register reads with key-word mode (bit 13) and update-allowed (bit 5) set and every other bit clear, which is 0x00002020. The timeout register (offset 0x8) reads DEF_TOVAL, and the counter register (offset 0x4) reads 0.
- R2: While the unlocked status bit (bit 11 of control, offset 0x0) is low, writes to the control register are ignored, except for clearing the flag (see R11). Writes to the timeout register are also ignored.
- R3: In key-word mode, writing 0xD928C520 to offset 0x4 sets the unlocked bit and clears the reconfiguration-done bit (bit 10) on the next clock.
- R4: In half-word mode (bit 13 clear), the unlock key is 0xC520 followed by 0xD928, as two consecutive writes to offset 0x4 using the low 16 bits of the write data. The unlocked bit stays low after the first half and goes high after the second.
- R5: A control or timeout write made while unlocked takes effect on the next clock, and it sets the reconfiguration-done bit.
- R6: The unlock window lasts UNLOCK_WIN clocks after the key. The window closes earlier on an accepted control write whose update-allowed bit (bit 5) is 0. Closing the window clears the unlocked bit.
- R7: With enable (bit 7) set, `wdog_rst` pulses for exactly one clock. The pulse comes TOVAL clocks after the enabling write. At the same time the count restarts from 0 and the flag (bit 14) is set.
- R8: With the prescaler bit (bit 12) set, the count advances once every 256 clocks.
- R9: A refresh key sets the count to 0. In key-word mode the key is the word 0xB480A602. In half-word mode it is 0xA602 followed by 0xB480.
- R10: A recognised first key half followed by a wrong second half pulses `wdog_rst` on the clock after that write and sets the flag. In half-word mode this means the next write to offset 0x4. In key-word mode it means the upper 16 bits of the same word. A write that matches no key half is ignored.
- R11: Writing 1 to bit 14 of the control register clears the flag, whether or not the block is unlocked.
- R12: The counter register reads the live count. While enable is clear, the count is held at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | One-cycle write strobe |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register (combinational) |
| wdog_rst | output | 1 | One-clock watchdog reset pulse |

## Verification
The key decoder is tried with:

- the correct word and half-word sequences for both keys;
- first halves followed by wrong second halves in each mode;
- words that match no key.

Together these separate "ignored" from "attack".

The counter is run with a short timeout both with and without the prescaler. The pulse must appear on the exact clock, which separates off-by-one errors in the comparison from errors in the prescaler.

Writes are tried while locked, inside the window, at its last clock, after it expires, and after an update-allowed-clear write. This covers every way the window can close.

// File: rtl/kwd_pkg.sv
package kwd_pkg;
  localparam logic [3:0] OFF_CTRL = 4'h0;
  localparam logic [3:0] OFF_CNT  = 4'h4;
  localparam logic [3:0] OFF_TOV  = 4'h8;

  localparam logic [15:0] UNLK_LO = 16'hC520;
  localparam logic [15:0] UNLK_HI = 16'hD928;
  localparam logic [15:0] RFSH_LO = 16'hA602;
  localparam logic [15:0] RFSH_HI = 16'hB480;

  localparam int B_FLAG  = 14;
  localparam int B_KEY32 = 13;
  localparam int B_PRES  = 12;
  localparam int B_ULK   = 11;
  localparam int B_DONE  = 10;
  localparam int B_EN    = 7;
  localparam int B_UPD   = 5;
  localparam int B_WAIT  = 1;
  localparam int B_STOP  = 0;

  typedef enum logic [1:0] {
    PEND_NONE,
    PEND_UNLK,
    PEND_RFSH
  } pend_e;
endpackage

// File: rtl/kwd_keydec.sv
module kwd_keydec
  import kwd_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        key32,
  input  logic        key_wr,
  input  logic [31:0] key_data,
  output logic        unlock_hit,
  output logic        refresh_hit,
  output logic        key_err
);
  pend_e pend_q;
  logic [15:0] lo, hi;
  assign lo = key_data[15:0];
  assign hi = key_data[31:16];

  always_comb begin
    unlock_hit  = 1'b0;
    refresh_hit = 1'b0;
    key_err     = 1'b0;
    if (key_wr) begin
      if (key32) begin
        unlock_hit  = (lo == UNLK_LO) && (hi == UNLK_HI);
        refresh_hit = (lo == RFSH_LO) && (hi == RFSH_HI);
        key_err     = ((lo == UNLK_LO) && (hi != UNLK_HI)) ||
                      ((lo == RFSH_LO) && (hi != RFSH_HI));
      end else begin
        case (pend_q)
          PEND_UNLK: begin
            unlock_hit = (lo == UNLK_HI);
            key_err    = (lo != UNLK_HI);
          end
          PEND_RFSH: begin
            refresh_hit = (lo == RFSH_HI);
            key_err     = (lo != RFSH_HI);
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= PEND_NONE;
    end else if (key32) begin
      pend_q <= PEND_NONE;
    end else if (key_wr) begin
      if (pend_q != PEND_NONE)  pend_q <= PEND_NONE;
      else if (lo == UNLK_LO)   pend_q <= PEND_UNLK;
      else if (lo == RFSH_LO)   pend_q <= PEND_RFSH;
    end
  end

  // R10: in half-word mode an error needs a pending first half
  assert_err_needs_pend_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (key_wr && !key32 && key_err) |-> (pend_q != PEND_NONE));
endmodule

// File: rtl/kwd_tick.sv
module kwd_tick #(
  parameter int PRE_W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic pres,
  output logic tick
);
  logic [PRE_W-1:0] pre_q;

  assign tick = pres ? (&pre_q) : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pre_q <= '0;
    else if (restart) pre_q <= '0;
    else              pre_q <= pre_q + 1'b1;
  end

  // R8: with the prescaler on, a tick is never followed directly by another
  assert_pres_spacing_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pres && tick && !restart) |=> !(pres && tick));
endmodule

// File: rtl/kwd_count.sv
module kwd_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clear,
  input  logic             tick,
  input  logic [CNT_W-1:0] toval,
  output logic [CNT_W-1:0] cnt,
  output logic             expire
);
  logic [CNT_W:0] nxt;
  assign nxt    = {1'b0, cnt} + 1'b1;
  assign expire = run && !clear && tick && (nxt >= {1'b0, toval});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (!run || clear)  cnt <= '0;
    else if (tick)           cnt <= expire ? '0 : nxt[CNT_W-1:0];
  end

  // R12: a disabled counter reads zero
  assert_hold_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt == '0));
  // R8: the count moves only on a tick
  assert_tick_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !clear && !tick) |=> $stable(cnt));
endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog
  import kwd_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int CNT_W      = 16,
  parameter int PRE_W      = 8,
  parameter int UNLOCK_WIN = 255,
  parameter int DEF_TOVAL  = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              wdog_rst
);
  localparam int WIN_W = $clog2(UNLOCK_WIN + 1);

  logic             key32_q, pres_q, en_q, upd_q, wait_q, stop_q;
  logic [1:0]       clksel_q;
  logic             flag_q, ulk_q, done_q, fire_q;
  logic [WIN_W-1:0] win_q;
  logic [CNT_W-1:0] toval_q, cnt;

  logic wr_ctrl, wr_cnt, wr_tov, cfg_ctrl, cfg_tov, close_now;
  logic unlock_hit, refresh_hit, key_err, tick, expire;

  assign wr_ctrl   = bus_wr && (bus_addr == ADDR_W'(OFF_CTRL));
  assign wr_cnt    = bus_wr && (bus_addr == ADDR_W'(OFF_CNT));
  assign wr_tov    = bus_wr && (bus_addr == ADDR_W'(OFF_TOV));
  assign cfg_ctrl  = wr_ctrl && ulk_q;
  assign cfg_tov   = wr_tov && ulk_q;
  assign close_now = cfg_ctrl && !bus_wdata[B_UPD];

  kwd_keydec u_keydec (
    .clk(clk), .rst_n(rst_n), .key32(key32_q), .key_wr(wr_cnt),
    .key_data(bus_wdata), .unlock_hit(unlock_hit),
    .refresh_hit(refresh_hit), .key_err(key_err)
  );

  kwd_tick #(.PRE_W(PRE_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .restart(!en_q || refresh_hit || key_err),
    .pres(pres_q), .tick(tick)
  );

  kwd_count #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .run(en_q), .clear(refresh_hit || key_err),
    .tick(tick), .toval(toval_q), .cnt(cnt), .expire(expire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key32_q  <= 1'b1;
      pres_q   <= 1'b0;
      clksel_q <= 2'b00;
      en_q     <= 1'b0;
      upd_q    <= 1'b1;
      wait_q   <= 1'b0;
      stop_q   <= 1'b0;
      toval_q  <= CNT_W'(DEF_TOVAL);
    end else begin
      if (cfg_ctrl) begin
        key32_q  <= bus_wdata[B_KEY32];
        pres_q   <= bus_wdata[B_PRES];
        clksel_q <= bus_wdata[9:8];
        en_q     <= bus_wdata[B_EN];
        upd_q    <= bus_wdata[B_UPD];
        wait_q   <= bus_wdata[B_WAIT];
        stop_q   <= bus_wdata[B_STOP];
      end
      if (cfg_tov) toval_q <= bus_wdata[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ulk_q  <= 1'b0;
      win_q  <= '0;
      done_q <= 1'b0;
    end else if (unlock_hit) begin
      ulk_q  <= 1'b1;
      win_q  <= WIN_W'(UNLOCK_WIN - 1);
      done_q <= 1'b0;
    end else begin
      if (cfg_ctrl || cfg_tov) done_q <= 1'b1;
      if (ulk_q) begin
        if (close_now || win_q == '0) ulk_q <= 1'b0;
        else                          win_q <= win_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fire_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      fire_q <= expire || key_err;
      if (expire || key_err)             flag_q <= 1'b1;
      else if (wr_ctrl && bus_wdata[B_FLAG]) flag_q <= 1'b0;
    end
  end

  assign wdog_rst = fire_q;

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(OFF_CTRL)) begin
      bus_rdata[B_FLAG]  = flag_q;
      bus_rdata[B_KEY32] = key32_q;
      bus_rdata[B_PRES]  = pres_q;
      bus_rdata[B_ULK]   = ulk_q;
      bus_rdata[B_DONE]  = done_q;
      bus_rdata[9:8]     = clksel_q;
      bus_rdata[B_EN]    = en_q;
      bus_rdata[B_UPD]   = upd_q;
      bus_rdata[B_WAIT]  = wait_q;
      bus_rdata[B_STOP]  = stop_q;
    end else if (bus_addr == ADDR_W'(OFF_CNT)) begin
      bus_rdata[CNT_W-1:0] = cnt;
    end else if (bus_addr == ADDR_W'(OFF_TOV)) begin
      bus_rdata[CNT_W-1:0] = toval_q;
    end
  end

  // R2: locked timeout writes change nothing
  assert_locked_tov_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_tov && !ulk_q) |=> $stable(toval_q));
  // R3: a decoded unlock opens the window with done cleared
  assert_unlock_opens_R3: assert property (@(posedge clk) disable iff (!rst_n)
    unlock_hit |=> (ulk_q && !done_q));
  // R7: every reset pulse leaves the flag set
  assert_fire_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fire_q |-> flag_q);
  // R7: the reset output is a single-clock pulse unless a new cause arrives
  assert_pulse_one_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_q && !expire && !key_err) |=> !fire_q);
endmodule

// File: tb/tb_keyed_wdog.sv
module tb_keyed_wdog;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = 4'h0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        wdog_rst;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  keyed_wdog dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wdog_rst(wdog_rst)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic ctrl_bit(input int b, output logic v);
    logic [31:0] d;
    rd(4'h0, d);
    v = d[b];
  endtask

  task automatic t_reset;
    logic [31:0] d;
    check("R1 rst", {31'b0, wdog_rst}, 0);
    rd(4'h0, d); check("R1 ctrl", d, 32'h2020);
    rd(4'h8, d); check("R1 toval", d, 1000);
    rd(4'h4, d); check("R1 cnt", d, 0);
  endtask

  task automatic t_locked;
    logic [31:0] d;
    wr(4'h8, 5);
    rd(4'h8, d); check("R2 locked toval", d, 1000);
    wr(4'h0, 32'h20A0);
    rd(4'h0, d); check("R2 locked ctrl", d, 32'h2020);
  endtask

  task automatic t_unlock32;
    logic v;
    wr(4'h4, 32'hD928C520);
    ctrl_bit(11, v); check("R3 unlocked", {31'b0, v}, 1);
    ctrl_bit(10, v); check("R3 done cleared", {31'b0, v}, 0);
  endtask

  task automatic t_timeout;
    logic [31:0] d;
    logic v;
    wr(4'h8, 10);
    rd(4'h8, d); check("R5 toval applied", d, 10);
    ctrl_bit(10, v); check("R5 done set", {31'b0, v}, 1);
    wr(4'h0, 32'h20A0);
    for (int n = 1; n <= 11; n++) begin
      @(negedge clk);
      if (n == 5) begin rd(4'h4, d); check("R12 live count", d, 5); end
      if (n == 9)  check("R7 no early pulse", {31'b0, wdog_rst}, 0);
      if (n == 10) begin
        check("R7 pulse at toval", {31'b0, wdog_rst}, 1);
        rd(4'h4, d); check("R7 count restarts", d, 0);
      end
      if (n == 11) check("R7 single pulse", {31'b0, wdog_rst}, 0);
    end
    ctrl_bit(14, v); check("R7 flag set", {31'b0, v}, 1);
  endtask

  task automatic t_refresh32;
    logic [31:0] d;
    wr(4'h4, 32'hD928C520);
    wr(4'h8, 100);
    repeat (4) @(negedge clk);
    wr(4'h4, 32'hB480A602);
    rd(4'h4, d); check("R9 refresh word", d, 0);
    repeat (3) @(negedge clk);
    rd(4'h4, d); check("R9 count resumes", d, 3);
  endtask

  task automatic t_w1c;
    logic v;
    wr(4'h0, 32'h60A0);
    ctrl_bit(14, v); check("R11 flag cleared", {31'b0, v}, 0);
  endtask

  task automatic t_window;
    logic [31:0] d;
    logic v;
    wr(4'h4, 32'hD928C520);
    repeat (254) @(negedge clk);
    ctrl_bit(11, v); check("R6 open at last clock", {31'b0, v}, 1);
    @(negedge clk);
    ctrl_bit(11, v); check("R6 closed after window", {31'b0, v}, 0);
    wr(4'h8, 50);
    rd(4'h8, d); check("R2 write after window", d, 100);
  endtask

  task automatic t_updclear;
    logic [31:0] d;
    logic v;
    wr(4'h4, 32'hD928C520);
    wr(4'h0, 32'h2080);
    ctrl_bit(11, v); check("R6 closed by upd clear", {31'b0, v}, 0);
    wr(4'h8, 50);
    rd(4'h8, d); check("R2 write after close", d, 100);
  endtask

  task automatic t_half_unlock;
    logic v;
    wr(4'h4, 32'hD928C520);
    wr(4'h0, 32'h00A0);
    wr(4'h0, 32'h0080);
    ctrl_bit(11, v); check("R6 relocked", {31'b0, v}, 0);
    wr(4'h4, 32'h0000C520);
    ctrl_bit(11, v); check("R4 first half only", {31'b0, v}, 0);
    wr(4'h4, 32'h0000D928);
    ctrl_bit(11, v); check("R4 half unlock", {31'b0, v}, 1);
  endtask

  task automatic t_half_refresh;
    logic [31:0] d;
    repeat (5) @(negedge clk);
    wr(4'h4, 32'h0000A602);
    wr(4'h4, 32'h0000B480);
    rd(4'h4, d); check("R9 refresh halves", d, 0);
  endtask

  task automatic t_err_half;
    logic v;
    wr(4'h0, 32'h4080);
    wr(4'h4, 32'h0000A602);
    check("R10 no pulse on first half", {31'b0, wdog_rst}, 0);
    wr(4'h4, 32'h00001234);
    check("R10 half error pulse", {31'b0, wdog_rst}, 1);
    ctrl_bit(14, v); check("R10 half error flag", {31'b0, v}, 1);
  endtask

  task automatic t_err_word;
    logic v;
    wr(4'h4, 32'h0000C520);
    wr(4'h4, 32'h0000D928);
    wr(4'h0, 32'h60A0);
    ctrl_bit(13, v); check("R5 back to word mode", {31'b0, v}, 1);
    wr(4'h4, 32'h12345678);
    check("R10 unknown word ignored", {31'b0, wdog_rst}, 0);
    wr(4'h4, 32'h0000A602);
    check("R10 word error pulse", {31'b0, wdog_rst}, 1);
  endtask

  task automatic t_prescale;
    logic [31:0] d;
    wr(4'h4, 32'hD928C520);
    wr(4'h8, 2);
    wr(4'h0, 32'h6020);
    wr(4'h0, 32'h30A0);
    for (int n = 1; n <= 512; n++) begin
      @(negedge clk);
      if (n == 255) begin rd(4'h4, d); check("R8 before first tick", d, 0); end
      if (n == 256) begin rd(4'h4, d); check("R8 first tick", d, 1); end
      if (n == 511) check("R8 no early pulse", {31'b0, wdog_rst}, 0);
      if (n == 512) check("R8 pulse at 2x256", {31'b0, wdog_rst}, 1);
    end
  endtask

  task automatic t_disable;
    logic [31:0] d;
    wr(4'h4, 32'hD928C520);
    wr(4'h0, 32'h2020);
    repeat (3) @(negedge clk);
    rd(4'h4, d); check("R12 disabled holds zero", d, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_locked();
    t_unlock32();
    t_timeout();
    t_refresh32();
    t_w1c();
    t_window();
    t_updclear();
    t_half_unlock();
    t_half_refresh();
    t_err_half();
    t_err_word();
    t_prescale();
    t_disable();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule